// File: doc/BRIEF.md
# Two-Sided Processor Handshake Register

This block gives two processors a shared handshake point. Each processor has its own register bus port and sees one 16-bit handshake register at a fixed byte address. Through it a processor publishes a 4-bit status nibble to the other side. It can also enable interrupt reception for itself, and it can send an interrupt request to the other side. The nibble a side writes shows up in the low nibble of the register the other side reads. A send request becomes a one-cycle interrupt pulse on the other side's interrupt output, but only if that side has reception enabled.

Each port accepts 8-, 16- and 32-bit writes. A byte write is merged with the other byte of the current halfword. A word write is split into two halfword writes. The register space is small: one halfword at byte address 2 holds the handshake register. The halfword at byte address 0 is an unused slot that reads as zero. Addresses at or beyond the end of the space read as zero and ignore writes. Read data is registered and arrives one cycle after the address.

Top module: `sync_hs_top`

## Requirements
- R1: After reset, both sides' registers read as zero and both interrupt outputs are low.
- R2: A halfword write to byte address 2 (or 3) stores only bit 14 (receive enable) and bits 11:8 (outgoing nibble) from the data. Reading that halfword gives bit 14 = own enable, bits 11:8 = own outgoing nibble, bits 3:0 = the peer's nibble, and every other bit 0. Bit 13 (send request) always reads 0.
- R3: A side's own write never changes bits 3:0 of its own register.
- R4: The bits 11:8 written by one side appear in bits 3:0 of the peer's register from the next cycle. The peer's enable and outgoing nibble stay unchanged.
- R5: A handshake write with bit 13 set, while the peer's bit 14 is already 1 before that cycle, drives the peer's interrupt output high for exactly the one cycle after the write. Otherwise no pulse occurs.
- R6: A byte write with address bit 0 = 0 replaces bits 7:0 with wdata[7:0]. With address bit 0 = 1 it replaces bits 15:8. The other byte comes from the current halfword. The merged value is then handled as a halfword write to the even address.
- R7: A word write uses the address with bits 1:0 cleared. wdata[15:0] goes to that halfword and wdata[31:16] to the halfword at that address plus 2.
- R8: Read data is registered. It shows the state as it was before any write in the cycle the address was presented, one cycle after that address.
- R9: Reads at addresses 4 and above, and at halfword 0, return zero. Writes there change nothing.
- R10: When both sides write the handshake register in the same cycle, both updates and both deliveries take effect.
- R11: If several write strobes of one port are high together, the word write wins over the halfword write, which wins over the byte write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_addr | input | ADDR_W | Side A byte address |
| a_wr8 | input | 1 | Side A byte write strobe |
| a_wr16 | input | 1 | Side A halfword write strobe |
| a_wr32 | input | 1 | Side A word write strobe |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 16 | Side A registered read data |
| a_irq | output | 1 | Interrupt pulse toward side A |
| b_addr | input | ADDR_W | Side B byte address |
| b_wr8 | input | 1 | Side B byte write strobe |
| b_wr16 | input | 1 | Side B halfword write strobe |
| b_wr32 | input | 1 | Side B word write strobe |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 16 | Side B registered read data |
| b_irq | output | 1 | Interrupt pulse toward side B |

## Verification
The assertions watch four things on every cycle:
- that a decoded write moves its nibble into the peer's low nibble;
- that an interrupt pulse appears exactly when a qualified send was decoded, and never otherwise;
- that a side's outgoing nibble holds when it does not write;
- that the send bit and out-of-range reads come back as zero.

Whether the lane merge, the word split, the address decode and strobe priority pick the right bits can only be shown by the bench's sweeps. These compare every port, address, write width and data pattern against a model computed in the bench. The same holds for the read latency and the same-cycle writes from both sides.

// File: rtl/sync_hs_pkg.sv
package sync_hs_pkg;
  localparam int HALF_W   = 16;
  localparam int NIB_W    = 4;
  localparam int BIT_EN   = 14;
  localparam int BIT_SEND = 13;
  localparam int OUT_LO   = 8;
  localparam int IN_LO    = 0;

  function automatic logic [HALF_W-1:0] pack_view(input logic en,
                                                  input logic [NIB_W-1:0] own_nib,
                                                  input logic [NIB_W-1:0] peer_nib);
    logic [HALF_W-1:0] v;
    v = '0;
    v[BIT_EN] = en;
    v[OUT_LO +: NIB_W] = own_nib;
    v[IN_LO +: NIB_W] = peer_nib;
    return v;
  endfunction
endpackage

// File: rtl/sync_hs_decode.sv
module sync_hs_decode #(
  parameter int ADDR_W    = 4,
  parameter int SYNC_ADDR = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr8,
  input  logic              wr16,
  input  logic              wr32,
  input  logic [31:0]       wdata,
  input  logic [15:0]       cur,
  output logic              hit,
  output logic [15:0]       hdata
);
  localparam logic [ADDR_W-1:0] SYNC_A = ADDR_W'(SYNC_ADDR);

  always_comb begin
    hit   = 1'b0;
    hdata = '0;
    if (wr32) begin
      if (addr[ADDR_W-1:2] == SYNC_A[ADDR_W-1:2]) begin
        hit   = 1'b1;
        hdata = SYNC_A[1] ? wdata[31:16] : wdata[15:0];
      end
    end else if (wr16) begin
      if (addr[ADDR_W-1:1] == SYNC_A[ADDR_W-1:1]) begin
        hit   = 1'b1;
        hdata = wdata[15:0];
      end
    end else if (wr8) begin
      if (addr[ADDR_W-1:1] == SYNC_A[ADDR_W-1:1]) begin
        hit   = 1'b1;
        hdata = addr[0] ? {wdata[7:0], cur[7:0]} : {cur[15:8], wdata[7:0]};
      end
    end
  end
endmodule

// File: rtl/sync_hs_rdport.sv
module sync_hs_rdport #(
  parameter int ADDR_W      = 4,
  parameter int SPACE_BYTES = 4,
  parameter int SYNC_ADDR   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       view,
  output logic [15:0]       rdata
);
  localparam logic [ADDR_W-1:0] SYNC_A  = ADDR_W'(SYNC_ADDR);
  localparam logic [ADDR_W:0]   SPACE_A = (ADDR_W+1)'(SPACE_BYTES);

  logic in_range, sel;
  assign in_range = {1'b0, addr} < SPACE_A;
  assign sel      = in_range && (addr[ADDR_W-1:1] == SYNC_A[ADDR_W-1:1]);

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel ? view : '0;
  end
endmodule

// File: rtl/sync_hs_top.sv
module sync_hs_top #(
  parameter int ADDR_W      = 4,
  parameter int SPACE_BYTES = 4,
  parameter int SYNC_ADDR   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_wr8,
  input  logic              a_wr16,
  input  logic              a_wr32,
  input  logic [31:0]       a_wdata,
  output logic [15:0]       a_rdata,
  output logic              a_irq,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_wr8,
  input  logic              b_wr16,
  input  logic              b_wr32,
  input  logic [31:0]       b_wdata,
  output logic [15:0]       b_rdata,
  output logic              b_irq
);
  import sync_hs_pkg::*;

  localparam int SIDES = 2;

  logic [SIDES-1:0][ADDR_W-1:0] addr_s;
  logic [SIDES-1:0]             wr8_s, wr16_s, wr32_s;
  logic [SIDES-1:0][31:0]       wdata_s;
  logic [SIDES-1:0][15:0]       rdata_s;
  logic [SIDES-1:0][15:0]       view;
  logic [SIDES-1:0]             wr_hit;
  logic [SIDES-1:0][15:0]       wr_data;

  logic [SIDES-1:0][NIB_W-1:0]  out_q;
  logic [SIDES-1:0]             en_q;
  logic [SIDES-1:0]             irq_q;

  assign addr_s  = {b_addr, a_addr};
  assign wr8_s   = {b_wr8, a_wr8};
  assign wr16_s  = {b_wr16, a_wr16};
  assign wr32_s  = {b_wr32, a_wr32};
  assign wdata_s = {b_wdata, a_wdata};

  generate
    for (genvar s = 0; s < SIDES; s++) begin : g_side
      assign view[s] = pack_view(en_q[s], out_q[s], out_q[SIDES-1-s]);

      sync_hs_decode #(.ADDR_W(ADDR_W), .SYNC_ADDR(SYNC_ADDR)) dec_i (
        .addr (addr_s[s]),
        .wr8  (wr8_s[s]),
        .wr16 (wr16_s[s]),
        .wr32 (wr32_s[s]),
        .wdata(wdata_s[s]),
        .cur  (view[s]),
        .hit  (wr_hit[s]),
        .hdata(wr_data[s])
      );

      sync_hs_rdport #(.ADDR_W(ADDR_W), .SPACE_BYTES(SPACE_BYTES),
                       .SYNC_ADDR(SYNC_ADDR)) rd_i (
        .clk  (clk),
        .rst  (rst),
        .addr (addr_s[s]),
        .view (view[s]),
        .rdata(rdata_s[s])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      en_q  <= '0;
      irq_q <= '0;
    end else begin
      for (int s = 0; s < SIDES; s++) begin
        irq_q[SIDES-1-s] <= wr_hit[s] & wr_data[s][BIT_SEND] & en_q[SIDES-1-s];
        if (wr_hit[s]) begin
          out_q[s] <= wr_data[s][OUT_LO +: NIB_W];
          en_q[s]  <= wr_data[s][BIT_EN];
        end
      end
    end
  end

  assign a_rdata = rdata_s[0];
  assign b_rdata = rdata_s[1];
  assign a_irq   = irq_q[0];
  assign b_irq   = irq_q[1];
endmodule

// File: rtl/sync_hs_chk.sv
module sync_hs_chk #(
  parameter int ADDR_W      = 4,
  parameter int SPACE_BYTES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] a_addr,
  input logic [ADDR_W-1:0] b_addr,
  input logic [15:0]       a_rdata,
  input logic [15:0]       b_rdata,
  input logic              a_irq,
  input logic              b_irq,
  input logic [1:0]        hit,
  input logic [15:0]       hd0,
  input logic [15:0]       hd1,
  input logic [15:0]       view0,
  input logic [15:0]       view1
);
  localparam logic [ADDR_W:0] SPACE_A = (ADDR_W+1)'(SPACE_BYTES);

  AST_RESET_CLEAR: assert property (@(posedge clk) $past(rst) |-> (a_rdata == 16'h0 && b_rdata == 16'h0 && !a_irq && !b_irq)); // R1
  AST_SEND_READ_ZERO: assert property (@(posedge clk) disable iff (rst) (a_rdata[13] == 1'b0 && b_rdata[13] == 1'b0)); // R2
  AST_OWN_HOLD_A: assert property (@(posedge clk) disable iff (rst) !hit[0] |=> $stable(view0[15:4])); // R4
  AST_OWN_HOLD_B: assert property (@(posedge clk) disable iff (rst) !hit[1] |=> $stable(view1[15:4])); // R4
  AST_DELIVER_AB: assert property (@(posedge clk) disable iff (rst) hit[0] |=> view1[3:0] == $past(hd0[11:8])); // R4
  AST_DELIVER_BA: assert property (@(posedge clk) disable iff (rst) hit[1] |=> view0[3:0] == $past(hd1[11:8])); // R10
  AST_IRQ_FIRE_B: assert property (@(posedge clk) disable iff (rst) (hit[0] && hd0[13] && view1[14]) |=> b_irq); // R5
  AST_IRQ_ONLY_B: assert property (@(posedge clk) disable iff (rst) b_irq |-> $past(hit[0] && hd0[13] && view1[14])); // R5
  AST_IRQ_FIRE_A: assert property (@(posedge clk) disable iff (rst) (hit[1] && hd1[13] && view0[14]) |=> a_irq); // R5
  AST_IRQ_ONLY_A: assert property (@(posedge clk) disable iff (rst) a_irq |-> $past(hit[1] && hd1[13] && view0[14])); // R5
  AST_OOR_READ_A: assert property (@(posedge clk) disable iff (rst) ({1'b0, $past(a_addr)} >= SPACE_A) |-> a_rdata == 16'h0); // R9
  AST_OOR_READ_B: assert property (@(posedge clk) disable iff (rst) ({1'b0, $past(b_addr)} >= SPACE_A) |-> b_rdata == 16'h0); // R9
endmodule

bind sync_hs_top sync_hs_chk #(.ADDR_W(ADDR_W), .SPACE_BYTES(SPACE_BYTES)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .a_addr (a_addr),
  .b_addr (b_addr),
  .a_rdata(a_rdata),
  .b_rdata(b_rdata),
  .a_irq  (a_irq),
  .b_irq  (b_irq),
  .hit    (wr_hit),
  .hd0    (wr_data[0]),
  .hd1    (wr_data[1]),
  .view0  (view[0]),
  .view1  (view[1])
);

// File: tb/sync_hs_top_tb_top.sv
module sync_hs_top_tb_top;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic a_wr8 = 0, a_wr16 = 0, a_wr32 = 0, b_wr8 = 0, b_wr16 = 0, b_wr32 = 0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [15:0] a_rdata, b_rdata;
  logic a_irq, b_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [3:0] m_out [2];
  logic       m_en  [2];

  always #5ns clk = ~clk;

  sync_hs_top #(.ADDR_W(AW), .SPACE_BYTES(4), .SYNC_ADDR(2)) dut_i (
    .clk(clk), .rst(rst),
    .a_addr(a_addr), .a_wr8(a_wr8), .a_wr16(a_wr16), .a_wr32(a_wr32),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq(a_irq),
    .b_addr(b_addr), .b_wr8(b_wr8), .b_wr16(b_wr16), .b_wr32(b_wr32),
    .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq(b_irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mview(int s);
    logic [15:0] v = '0;
    v[14]   = m_en[s];
    v[11:8] = m_out[s];
    v[3:0]  = m_out[1-s];
    return v;
  endfunction

  function automatic logic [15:0] mread(int s, logic [AW-1:0] a);
    return (a < 4 && a[AW-1:1] == 3'd1) ? mview(s) : 16'h0;
  endfunction

  // kind: 0 byte, 1 halfword, 2 word
  task automatic mdecode(int s, int kind, logic [AW-1:0] a, logic [31:0] d,
                         output bit hit, output logic [15:0] hd);
    logic [15:0] cur = mview(s);
    logic [AW-1:0] w = a & ~AW'(3);
    logic [AW-1:0] h = a & ~AW'(1);
    hit = 0; hd = '0;
    if (kind == 2) begin
      if (w == 2) begin hit = 1; hd = d[15:0]; end
      else if ((w | 2) == 2) begin hit = 1; hd = d[31:16]; end
    end else if (h == 2) begin
      hit = 1;
      if (kind == 1) hd = d[15:0];
      else hd = a[0] ? {d[7:0], cur[7:0]} : {cur[15:8], d[7:0]};
    end
  endtask

  task automatic drive(int s, int kind, logic [AW-1:0] a, logic [31:0] d);
    if (s == 0) begin
      a_addr = a; a_wdata = d;
      a_wr8 = (kind == 0); a_wr16 = (kind == 1); a_wr32 = (kind == 2);
    end else begin
      b_addr = a; b_wdata = d;
      b_wr8 = (kind == 0); b_wr16 = (kind == 1); b_wr32 = (kind == 2);
    end
  endtask

  task automatic idle();
    a_wr8 = 0; a_wr16 = 0; a_wr32 = 0; b_wr8 = 0; b_wr16 = 0; b_wr32 = 0;
  endtask

  task automatic do_write(int s, int kind, logic [AW-1:0] a, logic [31:0] d, string req);
    bit hit;
    logic [15:0] hd;
    logic exp_irq;
    @(negedge clk);
    drive(s, kind, a, d);
    mdecode(s, kind, a, d, hit, hd);
    exp_irq = hit & hd[13] & m_en[1-s];
    @(negedge clk);
    idle();
    check("R5", {31'b0, (s == 0) ? b_irq : a_irq}, {31'b0, exp_irq});
    check("R5", {31'b0, (s == 0) ? a_irq : b_irq}, 32'h0);
    if (hit) begin
      m_out[s] = hd[11:8];
      m_en[s]  = hd[14];
    end
    a_addr = 2; b_addr = 2;
    @(negedge clk);
    check(req, {16'h0, (s == 0) ? a_rdata : b_rdata}, {16'h0, mview(s)});
    check("R4", {16'h0, (s == 0) ? b_rdata : a_rdata}, {16'h0, mview(1-s)});
    check("R3", {28'h0, ((s == 0) ? a_rdata : b_rdata) & 16'hF}, {28'h0, m_out[1-s]});
    check("R5", {30'b0, a_irq, b_irq}, 32'h0);
  endtask

  task automatic do_read(logic [AW-1:0] a, string req);
    @(negedge clk);
    idle();
    a_addr = a; b_addr = a;
    @(negedge clk);
    check(req, {16'h0, a_rdata}, {16'h0, mread(0, a)});
    check(req, {16'h0, b_rdata}, {16'h0, mread(1, a)});
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_out[0] = 0; m_out[1] = 0; m_en[0] = 0; m_en[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {16'h0, a_rdata}, 32'h0);
    check("R1", {16'h0, b_rdata}, 32'h0);
    check("R1", {30'b0, a_irq, b_irq}, 32'h0);
    rst = 0;
    do_read(2, "R1");

    // halfword write with all bits set: only enable and nibble survive, send bit reads 0
    do_write(0, 1, 2, 32'h0000_FFFF, "R2");
    do_write(1, 1, 3, 32'h0000_BFFF, "R2");

    // exhaustive sweep over side, width, address and data pattern
    for (int s = 0; s < 2; s++)
      for (int kind = 0; kind < 3; kind++)
        for (int a = 0; a < 16; a++)
          for (int p = 0; p < 3; p++) begin
            logic [31:0] d;
            string req;
            d = (32'h9E37_79B9 * (a + 1)) ^ (32'h2545_F491 * (p + 3)) ^ (kind << 13);
            if (p == 2) d = d | 32'h6000_6000;
            req = (kind == 0) ? "R6" : (kind == 1) ? "R2" : "R7";
            if (a >= 4 || a < 2 && kind != 2) req = "R9";
            do_write(s, kind, AW'(a), d, req);
            do_read(AW'(a), "R9");
          end

    // receive disabled: send is dropped
    do_write(1, 1, 2, 32'h0000_0500, "R2");
    do_write(0, 1, 2, 32'h0000_2300, "R5");
    // receive enabled: send fires
    do_write(1, 1, 2, 32'h0000_4600, "R2");
    do_write(0, 1, 2, 32'h0000_2700, "R5");

    // read latency: same-cycle write not yet visible
    @(negedge clk);
    a_addr = 2; b_addr = 2;
    drive(0, 1, 2, 32'h0000_4C00);
    @(negedge clk);
    idle();
    check("R8", {16'h0, a_rdata}, {16'h0, mview(0)});
    m_out[0] = 4'hC; m_en[0] = 1;
    @(negedge clk);
    check("R8", {16'h0, a_rdata}, {16'h0, mview(0)});

    // simultaneous writes from both sides, both sending, both enabled
    @(negedge clk);
    drive(0, 1, 2, 32'h0000_6A00);
    drive(1, 1, 2, 32'h0000_6500);
    @(negedge clk);
    idle();
    check("R10", {30'b0, a_irq, b_irq}, 32'h3);
    m_out[0] = 4'hA; m_out[1] = 4'h5;
    @(negedge clk);
    check("R10", {16'h0, a_rdata}, 32'h0000_4A05);
    check("R10", {16'h0, b_rdata}, 32'h0000_450A);
    check("R10", {30'b0, a_irq, b_irq}, 32'h0);

    // strobe priority: word beats halfword beats byte
    @(negedge clk);
    a_addr = 0; a_wdata = 32'h0900_0300; a_wr32 = 1; a_wr16 = 1; a_wr8 = 1;
    @(negedge clk);
    idle();
    a_addr = 2;
    @(negedge clk);
    check("R11", {16'h0, a_rdata}, 32'h0000_0905);
    m_out[0] = 4'h9; m_en[0] = 0;
    @(negedge clk);
    a_addr = 2; a_wdata = 32'h0000_0D0E; a_wr16 = 1; a_wr8 = 1;
    @(negedge clk);
    idle();
    @(negedge clk);
    check("R11", {16'h0, a_rdata}, 32'h0000_0D05);
    check("R11", {16'h0, b_rdata}, 32'h0000_450D);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule